// File: doc/BRIEF.md
# Latency-Matrix Issue Interlock

This block is the hazard interlock at the issue stage of a single-issue, in-order pipeline with integer, load/store and floating-point add units. One instruction at a time sits in its issue register. The block keeps, for each architectural register, a short down-counter and the class of the instruction that last wrote it. From these it works out whether the instruction now waiting may go down the pipe this cycle.

The number of idle cycles owed between a producer and a consumer depends on the pair of instruction classes. A small latency matrix gives this number. One instruction that has no dependence can fill part of that gap. While the interlock holds an instruction back, it sends a bubble down the pipe, keeps the stalled instruction in the issue register and tells fetch to hold its word. The counters keep counting down throughout.

The block also marks the single branch delay slot. This is the first instruction that goes down the pipe after a branch. That instruction is never cancelled.

Top module: `hazard_interlock`

## Requirements
- R1: Synchronous active-high reset clears every counter and empties the issue register. In the cycle after reset, stall and goValid are 0, and a floating-point add that reads a register written just before the reset goes without delay.
- R2: A floating-point add (class 4) that reads the result of a floating-point add issues with at least 3 idle cycles between the two.
- R3: A store-double (class 3) that reads the result of a floating-point add issues with at least 2 idle cycles between the two.
- R4: A floating-point add that reads the result of a load-double (class 2) issues with at least 1 idle cycle between the two.
- R5: Every other producer and consumer pair of writing classes needs no idle cycle. This includes a load-double feeding a store-double and an integer op (class 1) feeding an integer op.
- R6: A branch (class 5) that tests the register written by the immediately preceding integer op stalls for exactly one cycle.
- R7: Each independent instruction issued between a producer and its consumer uses up one cycle of the gap, so the idle cycles equal max(0, gap - fillers).
- R8: The following never stall, and a producer that has no destination (classes 0, 3, 5) arms no counter:
  - reads of register 0;
  - writes to register 0;
  - sources a class does not read.

  The sources each class reads are: class 0 reads none, classes 2 and 5 read srcA only, and classes 1, 3 and 4 read srcA and srcB.
- R9: While stall is high:
  - goValid is 0;
  - the held instruction is neither lost nor duplicated, and it goes down the pipe exactly once with its class and destination unchanged;
  - stall is never high when the issue register is empty.
- R10: goSlot is 1 for exactly the first instruction that goes after a branch, with goValid high. This holds even when bubbles or empty cycles come between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchValid | input | 1 | Fetch offers an instruction |
| fetchCls | input | 3 | Class of the offered instruction: 0 none, 1 integer, 2 load-double, 3 store-double, 4 FP add, 5 branch |
| fetchDst | input | log2(NREG) | Destination register |
| fetchSrcA | input | log2(NREG) | First source register (base for memory ops, tested register for branch) |
| fetchSrcB | input | log2(NREG) | Second source register (data for store-double) |
| stall | output | 1 | Issue register is held; fetch must keep its word |
| goValid | output | 1 | An instruction goes down the pipe this cycle (0 means bubble) |
| goCls | output | 3 | Class of the instruction going down |
| goDst | output | log2(NREG) | Destination of the instruction going down |
| goSlot | output | 1 | The instruction going down sits in a branch delay slot |

## Verification
A counter that loads too short a value, or a class lookup that picks the wrong row of the matrix, makes a consumer go down the pipe one or more cycles early. This shows up as a wrong issue-to-issue distance within at most three cycles of the producer. A counter that sticks or loads too long a value shows up as extra idle cycles, or as a stall on an instruction that has no dependence. A lost or duplicated held instruction, or a slot flag placed on the wrong instruction, is visible at the go outputs within the same pair of instructions.

// File: rtl/hazard_interlock_pkg.sv
package hazard_interlock_pkg;

  typedef enum logic [2:0] {
    CLS_NOP    = 3'd0,
    CLS_INT    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_FPALU  = 3'd4,
    CLS_BRANCH = 3'd5
  } opClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;  // load issue register from fetch
    logic commit;   // arm the destination counter of the issuing instruction
  } dpStrobe_t;

endpackage

// File: rtl/hazard_interlock_dp.sv
module hazard_interlock_dp
  import hazard_interlock_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int RW      = 5,
  parameter int CW      = 2,
  parameter int FP_MAX  = 3,
  parameter int LD_MAX  = 1,
  parameter int INT_MAX = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  dpStrobe_t     strobe,
  input  logic          fetchValid,
  input  opClass_t      fetchCls,
  input  logic [RW-1:0] fetchDst,
  input  logic [RW-1:0] fetchSrcA,
  input  logic [RW-1:0] fetchSrcB,
  output logic          isValid,
  output opClass_t      isCls,
  output logic [RW-1:0] isDst,
  output logic [RW-1:0] isSrcA,
  output logic [RW-1:0] isSrcB,
  output logic [CW-1:0] cntA,
  output logic [CW-1:0] cntB,
  output opClass_t      clsA,
  output opClass_t      clsB
);

  logic [CW-1:0] regCnt  [NREG];
  opClass_t      regProd [NREG];
  logic [CW-1:0] loadVal;

  // issue register
  always_ff @(posedge clk) begin
    if (rst) begin
      isValid <= 1'b0;
      isCls   <= CLS_NOP;
      isDst   <= '0;
      isSrcA  <= '0;
      isSrcB  <= '0;
    end else if (strobe.advance) begin
      isValid <= fetchValid;
      isCls   <= fetchCls;
      isDst   <= fetchDst;
      isSrcA  <= fetchSrcA;
      isSrcB  <= fetchSrcB;
    end
  end

  // longest gap any consumer may owe this producer class
  always_comb begin
    case (isCls)
      CLS_FPALU: loadVal = CW'(FP_MAX);
      CLS_LOAD:  loadVal = CW'(LD_MAX);
      CLS_INT:   loadVal = CW'(INT_MAX);
      default:   loadVal = '0;
    endcase
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regCnt[r]  <= '0;
        regProd[r] <= CLS_NOP;
      end else if (strobe.commit && isDst == RW'(r)) begin
        regCnt[r]  <= loadVal;
        regProd[r] <= isCls;
      end else if (regCnt[r] != '0) begin
        regCnt[r]  <= regCnt[r] - 1'b1;
      end
    end
  end

  assign cntA = regCnt[isSrcA];
  assign cntB = regCnt[isSrcB];
  assign clsA = regProd[isSrcA];
  assign clsB = regProd[isSrcB];

endmodule

// File: rtl/hazard_interlock_ctrl.sv
module hazard_interlock_ctrl
  import hazard_interlock_pkg::*;
#(
  parameter int RW      = 5,
  parameter int CW      = 2,
  parameter int FF_GAP  = 3,
  parameter int FS_GAP  = 2,
  parameter int LF_GAP  = 1,
  parameter int IB_GAP  = 1,
  parameter int FP_MAX  = 3,
  parameter int LD_MAX  = 1,
  parameter int INT_MAX = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          isValid,
  input  opClass_t      isCls,
  input  logic [RW-1:0] isDst,
  input  logic [RW-1:0] isSrcA,
  input  logic [RW-1:0] isSrcB,
  input  logic [CW-1:0] cntA,
  input  logic [CW-1:0] cntB,
  input  opClass_t      clsA,
  input  opClass_t      clsB,
  output dpStrobe_t     strobe,
  output logic          stall,
  output logic          goValid,
  output logic          goSlot
);

  function automatic int needOf(opClass_t p, opClass_t c);
    if (p == CLS_FPALU && c == CLS_FPALU)  return FF_GAP;
    if (p == CLS_FPALU && c == CLS_STORE)  return FS_GAP;
    if (p == CLS_LOAD  && c == CLS_FPALU)  return LF_GAP;
    if (p == CLS_INT   && c == CLS_BRANCH) return IB_GAP;
    return 0;
  endfunction

  function automatic int maxOf(opClass_t p);
    case (p)
      CLS_FPALU: return FP_MAX;
      CLS_LOAD:  return LD_MAX;
      CLS_INT:   return INT_MAX;
      default:   return 0;
    endcase
  endfunction

  logic readsA, readsB, hasDest, blkA, blkB, afterBranch;

  always_comb begin
    readsA  = (isCls != CLS_NOP);
    readsB  = (isCls == CLS_INT) || (isCls == CLS_STORE) || (isCls == CLS_FPALU);
    hasDest = (isCls == CLS_INT) || (isCls == CLS_LOAD)  || (isCls == CLS_FPALU);
    // remaining wait is the counter minus the slack this consumer enjoys
    blkA = readsA && (isSrcA != '0) &&
           (int'(cntA) > maxOf(clsA) - needOf(clsA, isCls));
    blkB = readsB && (isSrcB != '0) &&
           (int'(cntB) > maxOf(clsB) - needOf(clsB, isCls));
  end

  assign stall          = isValid && (blkA || blkB);
  assign goValid        = isValid && !stall;
  assign goSlot         = goValid && afterBranch;
  assign strobe.advance = !stall;
  assign strobe.commit  = goValid && hasDest && (isDst != '0);

  always_ff @(posedge clk) begin
    if (rst)          afterBranch <= 1'b0;
    else if (goValid) afterBranch <= (isCls == CLS_BRANCH);
  end

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import hazard_interlock_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int FF_GAP = 3,
  parameter int FS_GAP = 2,
  parameter int LF_GAP = 1,
  parameter int IB_GAP = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fetchValid,
  input  logic [2:0]               fetchCls,
  input  logic [$clog2(NREG)-1:0]  fetchDst,
  input  logic [$clog2(NREG)-1:0]  fetchSrcA,
  input  logic [$clog2(NREG)-1:0]  fetchSrcB,
  output logic                     stall,
  output logic                     goValid,
  output logic [2:0]               goCls,
  output logic [$clog2(NREG)-1:0]  goDst,
  output logic                     goSlot
);

  localparam int RW      = $clog2(NREG);
  localparam int FP_MAX  = (FF_GAP > FS_GAP) ? FF_GAP : FS_GAP;
  localparam int LD_MAX  = LF_GAP;
  localparam int INT_MAX = IB_GAP;
  localparam int MAX_A   = (FP_MAX > LD_MAX) ? FP_MAX : LD_MAX;
  localparam int MAX_GAP = (MAX_A > INT_MAX) ? MAX_A : INT_MAX;
  localparam int CW      = (MAX_GAP > 1) ? $clog2(MAX_GAP + 1) : 1;

  dpStrobe_t     strobe;
  logic          isValid;
  opClass_t      isCls, clsA, clsB;
  logic [RW-1:0] isDst, isSrcA, isSrcB;
  logic [CW-1:0] cntA, cntB;

  hazard_interlock_dp #(
    .NREG(NREG), .RW(RW), .CW(CW),
    .FP_MAX(FP_MAX), .LD_MAX(LD_MAX), .INT_MAX(INT_MAX)
  ) dp_i (
    .clk, .rst, .strobe,
    .fetchValid, .fetchCls(opClass_t'(fetchCls)),
    .fetchDst, .fetchSrcA, .fetchSrcB,
    .isValid, .isCls, .isDst, .isSrcA, .isSrcB,
    .cntA, .cntB, .clsA, .clsB
  );

  hazard_interlock_ctrl #(
    .RW(RW), .CW(CW),
    .FF_GAP(FF_GAP), .FS_GAP(FS_GAP), .LF_GAP(LF_GAP), .IB_GAP(IB_GAP),
    .FP_MAX(FP_MAX), .LD_MAX(LD_MAX), .INT_MAX(INT_MAX)
  ) ctrl_i (
    .clk, .rst, .isValid, .isCls, .isDst, .isSrcA, .isSrcB,
    .cntA, .cntB, .clsA, .clsB,
    .strobe, .stall, .goValid, .goSlot
  );

  assign goCls = isCls;
  assign goDst = isDst;

endmodule

// File: rtl/hazard_interlock_chk.sv
module hazard_interlock_chk #(
  parameter int MAX_GAP = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       stall,
  input logic       goValid,
  input logic [2:0] goCls,
  input logic       goSlot,
  input logic       isValid,
  input logic [2:0] isCls
);

  logic [7:0] stallRun;

  always_ff @(posedge clk) begin
    if (rst)        stallRun <= '0;
    else if (stall) stallRun <= (stallRun == 8'hff) ? stallRun : stallRun + 8'd1;
    else            stallRun <= '0;
  end

  AST_BUBBLE_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    stall |-> !goValid); // R9

  AST_EMPTY_NEVER_HELD: assert property (@(posedge clk) disable iff (rst)
    !isValid |-> !stall); // R9

  AST_NOP_NEVER_HELD: assert property (@(posedge clk) disable iff (rst)
    (isValid && isCls == 3'd0) |-> !stall); // R8

  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    stall |-> (int'(stallRun) < MAX_GAP)); // R7

  AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!stall && !goValid)); // R1

  AST_SLOT_ONLY_ON_GO: assert property (@(posedge clk) disable iff (rst)
    goSlot |-> goValid); // R10

  AST_SLOT_FOLLOWS_BRANCH: assert property (@(posedge clk) disable iff (rst)
    ($past(goValid) && $past(goCls) == 3'd5 && !$past(rst) && goValid) |-> goSlot); // R10

endmodule

bind hazard_interlock hazard_interlock_chk #(.MAX_GAP(MAX_GAP)) chk_i (
  .clk(clk), .rst(rst), .stall(stall), .goValid(goValid), .goCls(goCls),
  .goSlot(goSlot), .isValid(isValid), .isCls(isCls)
);

// File: tb/hazard_interlock_tb.sv
module hazard_interlock_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int RW = $clog2(NREG);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fetchValid = 1'b0;
  logic [2:0]    fetchCls = 3'd0;
  logic [RW-1:0] fetchDst = '0, fetchSrcA = '0, fetchSrcB = '0;
  logic          stall, goValid, goSlot;
  logic [2:0]    goCls;
  logic [RW-1:0] goDst;

  hazard_interlock #(.NREG(NREG)) dut_i (
    .clk, .rst, .fetchValid, .fetchCls, .fetchDst, .fetchSrcA, .fetchSrcB,
    .stall, .goValid, .goCls, .goDst, .goSlot
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0, evCount = 0, acceptCyc = 0;
  bit done = 0;
  int evCyc [1024];
  logic [2:0] evCls [1024];
  logic [RW-1:0] evDst [1024];
  logic evSlot [1024];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (goValid && evCount < 1024) begin
      evCyc[evCount]  = cyc;
      evCls[evCount]  = goCls;
      evDst[evCount]  = goDst;
      evSlot[evCount] = goSlot;
      evCount = evCount + 1;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send(input int c, input int d, input int a, input int b);
    @(negedge clk);
    fetchValid = 1'b1;
    fetchCls = 3'(c); fetchDst = RW'(d); fetchSrcA = RW'(a); fetchSrcB = RW'(b);
    while (stall) @(negedge clk);
    acceptCyc = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fetchValid = 1'b0;
      fetchCls = 3'd0;
    end
  endtask

  // gap owed by the requirements
  function automatic int needOf(int p, int c);
    if (p == 4 && c == 4) return 3; // R2
    if (p == 4 && c == 3) return 2; // R3
    if (p == 2 && c == 4) return 1; // R4
    if (p == 1 && c == 5) return 1; // R6
    return 0;
  endfunction

  function automatic bit readsB(int c);
    return (c == 1) || (c == 3) || (c == 4);
  endfunction

  function automatic string tagFor(int p, int c, int k, bit useB);
    int n = needOf(p, c);
    if (useB && !readsB(c)) return "R8";
    if (p == 0 || p == 3 || p == 5) return "R8";
    if (n == 0) return "R5";
    if (k > 0) return "R7";
    if (p == 4 && c == 4) return "R2";
    if (p == 4) return "R3";
    if (p == 2) return "R4";
    return "R6";
  endfunction

  task automatic runPair(input int p, input int c, input int k, input bit useB);
    int base, exp, act;
    string tag;
    base = evCount;
    send(p, 5, 0, 0);
    for (int i = 0; i < k; i++) send(0, 0, 0, 0);
    if (useB) send(c, 7, 0, 5);
    else      send(c, 7, 5, 0);
    idle(7);
    tag = tagFor(p, c, k, useB);
    exp = needOf(p, c) - k;
    if (useB && !readsB(c)) exp = 0;
    if (exp < 0) exp = 0;
    check("R9", $sformatf("event count p=%0d c=%0d k=%0d", p, c, k), evCount - base, k + 2);
    if (evCount - base == k + 2) begin
      act = evCyc[base + k + 1] - evCyc[base] - 1 - k;
      check(tag, $sformatf("idle cycles p=%0d c=%0d k=%0d srcB=%0d", p, c, k, useB), act, exp);
      check("R9", "held instruction class", int'(evCls[base + k + 1]), c);
      check("R9", "held instruction dst", int'(evDst[base + k + 1]), 7);
    end
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "stall after reset", int'(stall), 0);
    check("R1", "goValid after reset", int'(goValid), 0);

    // full sweep of producer x consumer x filler count, dependence on srcA
    for (int p = 0; p <= 5; p++)
      for (int c = 1; c <= 5; c++)
        for (int k = 0; k <= 3; k++)
          runPair(p, c, k, 1'b0);
    // dependence through srcB
    for (int p = 0; p <= 5; p++)
      for (int c = 1; c <= 5; c++)
        runPair(p, c, 0, 1'b1);

    // R8: register zero as destination and source
    base = evCount;
    send(4, 0, 0, 0);
    send(4, 7, 0, 0);
    idle(6);
    if (evCount - base == 2)
      check("R8", "register zero idle cycles", evCyc[base+1] - evCyc[base] - 1, 0);
    else check("R8", "register zero event count", evCount - base, 2);

    // R10: delay slot marking, with a stalled slot and a slot after empty cycles
    base = evCount;
    send(4, 3, 0, 0);
    send(5, 0, 0, 0);
    send(4, 4, 3, 0);
    send(0, 0, 0, 0);
    send(5, 0, 0, 0);
    idle(2);
    send(1, 6, 0, 0);
    send(0, 0, 0, 0);
    idle(6);
    check("R10", "event count", evCount - base, 7);
    if (evCount - base == 7) begin
      check("R10", "slot on producer", int'(evSlot[base]), 0);
      check("R10", "slot on branch", int'(evSlot[base+1]), 0);
      check("R10", "slot on stalled fp add", int'(evSlot[base+2]), 1);
      check("R10", "slot after slot", int'(evSlot[base+3]), 0);
      check("R10", "slot on second branch", int'(evSlot[base+4]), 0);
      check("R10", "slot across empty cycles", int'(evSlot[base+5]), 1);
      check("R10", "slot on last", int'(evSlot[base+6]), 0);
      check("R7", "fp gap across branch", evCyc[base+2] - evCyc[base] - 2, 2);
    end

    // R1: reset while a consumer is held
    send(4, 9, 0, 0);
    send(4, 10, 9, 0);
    idle(1);
    check("R2", "consumer held before reset", int'(stall), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "stall after mid reset", int'(stall), 0);
    check("R1", "goValid after mid reset", int'(goValid), 0);
    base = evCount;
    send(4, 11, 9, 0);
    idle(6);
    check("R1", "event count after reset", evCount - base, 1);
    if (evCount - base == 1)
      check("R1", "consumer goes without delay", evCyc[base], acceptCyc + 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule